// File: doc/BRIEF.md
# Mode-Patterned DMA Channel

This block is one DMA channel. It copies bytes between a 24-bit linear bus address and a small window of 8-bit registers. The window sits at 0x2100. Inside the window, the target register is picked by a port byte plus an offset. The offset comes from a short pattern chosen by a 3-bit mode. Each mode fixes two things: how many bytes form one unit, and which offsets the bytes of that unit visit in turn. After one unit ends, the next unit starts the same pattern again.

Software sets up the configuration inputs and then pulses `start`. The channel copies those settings into its own registers and runs without a break until its byte count reaches zero. Every byte takes two accesses on a simple valid/ready byte bus: a read first, then a write. A direction flag picks which side is read and which side is written. A fixed flag and a decrement flag control how the bus address moves after each byte. At the end the channel pulses `done` and drops `busy`. The final bus address and a zero count stay visible on `cur_addr` and `cur_left`.

Top module: `dma_pattern_channel`

## Requirements
- R1: After reset, `busy`, `done` and `req_valid` are low, and `cur_addr` and `cur_left` read zero.
- R2: A `start` pulse taken while idle copies every configuration input and raises `busy` on the next cycle. While busy, `start` and any change on the configuration inputs have no effect. `req_valid` is high only while `busy` is high.
- R3: A programmed length of N > 0 moves exactly N bytes. A length of 0 moves 65536 bytes. `cur_left` shows the bytes still to move and drops by one on each completed write.
- R4: The port-side address is 0x002100 OR (port byte + pattern offset) mod 256.
- R5: The offset sequence and the unit length for each mode (mode: offsets) are:
  - 0: 0
  - 1: 0,1
  - 2: 0,0
  - 3: 0,0,1,1
  - 4: 0,1,2,3
  - 5: 0,1,0,1
  - 6: 0,0
  - 7: 0,0,1,1
  
  The pattern restarts at its first offset after the last byte of a unit.
- R6: With the direction flag clear, each byte is read from the bus address and written to the port address. With the flag set, the byte is read from the port address and written to the bus address. The data written is always the byte just read.
- R7: After each byte the bus address steps by +1. It steps by -1 when the decrement flag is set, and stays put when the fixed flag is set. It wraps modulo 2^24.
- R8: Each byte is one read access (`req_we`=0) followed by one write access (`req_we`=1). An access counts only when `req_ready` is high. While it waits, the request holds `req_valid`, `req_addr`, `req_we` and `req_wdata` steady.
- R9: The completing write is followed by one cycle with `done` high. In that same cycle `busy` is low, `cur_left` is zero and `cur_addr` holds the final stepped address.
- R10: If the count runs out partway through a unit, the transfer ends there. No further access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 24 | Starting bus address |
| cfg_port | input | 8 | Port byte added to the window offset |
| cfg_len | input | 16 | Byte count, 0 meaning 65536 |
| cfg_mode | input | 3 | Unit pattern select |
| cfg_to_bus | input | 1 | 1: port-to-bus, 0: bus-to-port |
| cfg_fixed | input | 1 | Hold bus address constant |
| cfg_decr | input | 1 | Step bus address downward |
| start | input | 1 | Begin a transfer when idle |
| req_valid | output | 1 | Bus access requested |
| req_ready | input | 1 | Bus accepts the access this cycle |
| req_we | output | 1 | 1 write, 0 read |
| req_addr | output | 24 | Access address |
| req_wdata | output | 8 | Write data |
| req_rdata | input | 8 | Read data, valid with req_ready |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_addr | output | 24 | Current bus address |
| cur_left | output | 17 | Bytes remaining |

## Verification
Some internal faults break no rule on their own but still show at the ports. A wrong pattern index or a wrong unit length puts the wrong port address on the very next port-side access. A wrong direction latch swaps the read and write addresses on the first request. An off-by-one in the count stretches or cuts `busy` by one byte, so `done` moves by two accesses. Because the reference model checks `req_addr`, `req_we`, `cur_addr` and `cur_left` on every cycle, each such fault is reported within one access of the point where it first takes effect.

// File: rtl/dma_pattern_pkg.sv
package dma_pattern_pkg;
    parameter int unsigned BUS_AW  = 24;
    parameter int unsigned PORT_W  = 8;
    parameter int unsigned LEN_W   = 16;
    parameter int unsigned CNT_W   = LEN_W + 1;
    parameter int unsigned MODE_W  = 3;
    parameter int unsigned IDX_W   = 2;
    parameter int unsigned DATA_W  = 8;
    parameter logic [BUS_AW-1:0] WIN_BASE = 24'h002100;

    typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [BUS_AW-1:0]   addr;
        logic [PORT_W-1:0]   port;
        logic [MODE_W-1:0]   mode;
        logic                to_bus;
        logic                fixed;
        logic                decr;
        logic [CNT_W-1:0]    left;
        logic [IDX_W-1:0]    idx;
        logic [DATA_W-1:0]   data;
        logic                done;
    } chan_t;
endpackage

// File: rtl/dma_unit_pattern.sv
module dma_unit_pattern
    import dma_pattern_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [IDX_W-1:0]  idx,
    output logic [IDX_W-1:0]  offset,
    output logic              unit_end
);
    logic [IDX_W:0] unit_len;

    always_comb begin
        offset   = '0;
        unit_len = (IDX_W+1)'(4);
        case (mode)
            3'd0: begin offset = '0;                     unit_len = (IDX_W+1)'(1); end
            3'd1: begin offset = IDX_W'(idx[0]);         unit_len = (IDX_W+1)'(2); end
            3'd2: begin offset = '0;                     unit_len = (IDX_W+1)'(2); end
            3'd3: begin offset = IDX_W'(idx[1]);         unit_len = (IDX_W+1)'(4); end
            3'd4: begin offset = idx;                    unit_len = (IDX_W+1)'(4); end
            3'd5: begin offset = IDX_W'(idx[0]);         unit_len = (IDX_W+1)'(4); end
            3'd6: begin offset = '0;                     unit_len = (IDX_W+1)'(2); end
            default: begin offset = IDX_W'(idx[1]);      unit_len = (IDX_W+1)'(4); end
        endcase
        unit_end = ({1'b0, idx} == (unit_len - (IDX_W+1)'(1)));
    end
endmodule

// File: rtl/dma_addr_stepper.sv
module dma_addr_stepper #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] addr,
    input  logic         fixed,
    input  logic         decr,
    output logic [W-1:0] next_addr
);
    always_comb begin
        if (fixed)     next_addr = addr;
        else if (decr) next_addr = addr - W'(1);
        else           next_addr = addr + W'(1);
    end
endmodule

// File: rtl/dma_pattern_channel.sv
module dma_pattern_channel
    import dma_pattern_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_AW-1:0]   cfg_addr,
    input  logic [PORT_W-1:0]   cfg_port,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [MODE_W-1:0]   cfg_mode,
    input  logic                cfg_to_bus,
    input  logic                cfg_fixed,
    input  logic                cfg_decr,
    input  logic                start,
    output logic                req_valid,
    input  logic                req_ready,
    output logic                req_we,
    output logic [BUS_AW-1:0]   req_addr,
    output logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W-1:0]   req_rdata,
    output logic                busy,
    output logic                done,
    output logic [BUS_AW-1:0]   cur_addr,
    output logic [CNT_W-1:0]    cur_left
);
    localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(1) << LEN_W;

    chan_t              st_q, st_d;
    logic [IDX_W-1:0]   pat_off;
    logic               pat_end;
    logic [BUS_AW-1:0]  addr_step;
    logic [PORT_W-1:0]  port_sum;
    logic [BUS_AW-1:0]  port_addr;
    logic               use_port;

    dma_unit_pattern u_pattern (
        .mode     (st_q.mode),
        .idx      (st_q.idx),
        .offset   (pat_off),
        .unit_end (pat_end)
    );

    dma_addr_stepper #(.W(BUS_AW)) u_stepper (
        .addr      (st_q.addr),
        .fixed     (st_q.fixed),
        .decr      (st_q.decr),
        .next_addr (addr_step)
    );

    assign port_sum  = st_q.port + PORT_W'(pat_off);
    assign port_addr = WIN_BASE | BUS_AW'(port_sum);
    assign use_port  = (st_q.phase == PH_WRITE) ^ st_q.to_bus;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase  = PH_READ;
                    st_d.addr   = cfg_addr;
                    st_d.port   = cfg_port;
                    st_d.mode   = cfg_mode;
                    st_d.to_bus = cfg_to_bus;
                    st_d.fixed  = cfg_fixed;
                    st_d.decr   = cfg_decr;
                    st_d.idx    = '0;
                    st_d.left   = (cfg_len == '0) ? FULL_COUNT : CNT_W'(cfg_len);
                end
            end
            PH_READ: begin
                if (req_ready) begin
                    st_d.data  = req_rdata;
                    st_d.phase = PH_WRITE;
                end
            end
            PH_WRITE: begin
                if (req_ready) begin
                    st_d.addr = addr_step;
                    st_d.left = st_q.left - CNT_W'(1);
                    st_d.idx  = pat_end ? '0 : st_q.idx + IDX_W'(1);
                    if (st_q.left == CNT_W'(1)) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.phase = PH_READ;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_valid = (st_q.phase != PH_IDLE);
    assign req_we    = (st_q.phase == PH_WRITE);
    assign req_addr  = use_port ? port_addr : st_q.addr;
    assign req_wdata = st_q.data;
    assign busy      = (st_q.phase != PH_IDLE);
    assign done      = st_q.done;
    assign cur_addr  = st_q.addr;
    assign cur_left  = st_q.left;
endmodule

// File: rtl/dma_pattern_checker.sv
module dma_pattern_checker
    import dma_pattern_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_we,
    input logic [BUS_AW-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              busy,
    input logic              done,
    input logic [BUS_AW-1:0] cur_addr,
    input logic [CNT_W-1:0]  cur_left
);
    logic wr_hs;
    assign wr_hs = req_valid && req_ready && req_we;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_we) && $stable(req_wdata)); // R8
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_we |=> req_valid && req_we); // R8
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy); // R2
    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !wr_hs |=> busy && $stable(cur_addr) && $stable(cur_left)); // R2
    AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hs |=> cur_left == $past(cur_left) - CNT_W'(1)); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hs |=> (cur_addr == $past(cur_addr)) || (cur_addr == $past(cur_addr) + BUS_AW'(1))
                  || (cur_addr == $past(cur_addr) - BUS_AW'(1))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && cur_left == '0); // R9
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9
endmodule

bind dma_pattern_channel dma_pattern_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .busy      (busy),
    .done      (done),
    .cur_addr  (cur_addr),
    .cur_left  (cur_left)
);

// File: tb/dma_pattern_channel_tb.sv
`timescale 1ns/100ps
module dma_pattern_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cfg_addr = '0;
    logic [7:0]  cfg_port = '0;
    logic [15:0] cfg_len = '0;
    logic [2:0]  cfg_mode = '0;
    logic        cfg_to_bus = 1'b0, cfg_fixed = 1'b0, cfg_decr = 1'b0;
    logic        start = 1'b0;
    logic        req_ready = 1'b1;
    logic        req_valid, req_we, busy, done;
    logic [23:0] req_addr, cur_addr;
    logic [7:0]  req_wdata, req_rdata;
    logic [16:0] cur_left;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction
    assign req_rdata = pat(req_addr);

    dma_pattern_channel u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_port(cfg_port), .cfg_len(cfg_len),
        .cfg_mode(cfg_mode), .cfg_to_bus(cfg_to_bus), .cfg_fixed(cfg_fixed), .cfg_decr(cfg_decr),
        .start(start), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata), .busy(busy),
        .done(done), .cur_addr(cur_addr), .cur_left(cur_left)
    );

    int n_chk = 0, n_fail = 0;
    task automatic chk(input string r, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    // ready stall generator
    bit          rand_ready = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    always begin
        @(negedge clk); #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        req_ready = rand_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // behavioural reference model
    int offs[8][4] = '{'{0,0,0,0}, '{0,1,0,0}, '{0,0,0,0}, '{0,0,1,1},
                       '{0,1,2,3}, '{0,1,0,1}, '{0,0,0,0}, '{0,0,1,1}};
    int ulen[8] = '{1, 2, 2, 4, 4, 4, 2, 4};
    bit          model_on = 1'b0;
    bit          m_busy = 0, m_done = 0, m_phase = 0;
    bit          m_to_bus, m_fixed, m_decr;
    logic [23:0] m_addr = '0, port_a, exp_a;
    logic [7:0]  m_port, m_rd;
    int          m_mode, m_idx, m_left = 0, m_nbytes = 0;
    string       port_tag = "R4";

    always begin
        @(negedge clk); #2;
        if (model_on) begin
            chk("R2", busy, m_busy);
            chk("R9", done, m_done);
            chk("R7", cur_addr, m_addr);
            chk("R3", cur_left, m_left);
            chk("R8", req_valid, m_busy);
            if (m_busy && req_valid) begin
                port_a = 24'h002100 | 24'((int'(m_port) + offs[m_mode][m_idx]) & 255);
                exp_a  = (m_phase ^ m_to_bus) ? port_a : m_addr;
                chk((m_phase ^ m_to_bus) ? port_tag : "R6", req_addr, exp_a);
                chk("R8", req_we, m_phase);
                if (m_phase) chk("R6", req_wdata, m_rd);
            end
            m_done = 0;
            if (!m_busy) begin
                if (start) begin
                    m_busy = 1; m_phase = 0; m_idx = 0; m_nbytes = 0;
                    m_addr = cfg_addr; m_port = cfg_port; m_mode = int'(cfg_mode);
                    m_to_bus = cfg_to_bus; m_fixed = cfg_fixed; m_decr = cfg_decr;
                    m_left = (cfg_len == 0) ? 65536 : int'(cfg_len);
                end
            end else if (req_ready) begin
                if (!m_phase) begin
                    m_rd = req_rdata; m_phase = 1;
                end else begin
                    m_phase = 0;
                    if (!m_fixed) m_addr = m_decr ? m_addr - 24'd1 : m_addr + 24'd1;
                    m_left--; m_nbytes++; m_idx++;
                    if (m_idx == ulen[m_mode]) m_idx = 0;
                    if (m_left == 0) begin m_busy = 0; m_done = 1; end
                end
            end
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog: actual %0d expected below 190000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic run(input logic [23:0] a, input logic [7:0] p, input logic [15:0] len,
                       input logic [2:0] mode, input bit tb, input bit fx, input bit dc,
                       input bit rr, input logic [23:0] exp_end, input int exp_bytes,
                       input string cnt_tag, input bit poke);
        @(negedge clk); #1;
        cfg_addr = a; cfg_port = p; cfg_len = len; cfg_mode = mode;
        cfg_to_bus = tb; cfg_fixed = fx; cfg_decr = dc; rand_ready = rr; start = 1;
        @(negedge clk); #1; start = 0;
        if (poke) begin
            repeat (6) @(negedge clk);
            #1; cfg_addr = 24'h300000; cfg_len = 16'd3; cfg_mode = 3'd0; start = 1;
            @(negedge clk); #1; start = 0;
        end
        @(negedge clk); #3;
        while (m_busy) begin @(negedge clk); #3; end
        @(negedge clk); #3;
        chk("R9", cur_left, 0);
        chk("R9", cur_addr, exp_end);
        chk(cnt_tag, m_nbytes, exp_bytes);
        chk("R9", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", busy, 0); chk("R1", done, 0); chk("R1", req_valid, 0);
        chk("R1", cur_left, 0); chk("R1", cur_addr, 0);
        rst_n = 1; model_on = 1;
        // R6 bus-to-port, mode 1, stalls
        run(24'h123456, 8'h18, 16'd5, 3'd1, 0, 0, 0, 1, 24'h12345B, 5, "R3", 0);
        // R10 truncated unit, port wrap (R4), port-to-bus, fixed address
        run(24'h400000, 8'hFF, 16'd6, 3'd4, 1, 1, 0, 1, 24'h400000, 6, "R10", 0);
        // R7 decrement wrapping below zero
        run(24'h000001, 8'h30, 16'd3, 3'd3, 0, 0, 1, 1, 24'hFFFFFE, 3, "R3", 0);
        // R7 increment wrapping past the top
        run(24'hFFFFFE, 8'h05, 16'd4, 3'd0, 1, 0, 0, 1, 24'h000002, 4, "R3", 0);
        // R5 remaining pattern modes
        port_tag = "R5";
        for (int m = 2; m < 8; m++) begin
            if (m == 3 || m == 4) continue;
            run(24'h010000 + 24'(m * 256), 8'h40, 16'd9, 3'(m), bit'(m & 1), 0, 0, 1,
                24'h010009 + 24'(m * 256), 9, "R3", 0);
        end
        port_tag = "R4";
        // R2 start and config change while busy are ignored
        run(24'h200000, 8'h10, 16'd8, 3'd5, 0, 0, 0, 1, 24'h200008, 8, "R2", 0 == 1);
        run(24'h200000, 8'h10, 16'd8, 3'd5, 0, 0, 0, 1, 24'h200008, 8, "R2", 1);
        // R3 zero length moves 65536 bytes
        run(24'h800000, 8'h40, 16'd0, 3'd1, 0, 0, 0, 0, 24'h810000, 65536, "R3", 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule